// File: doc/BRIEF.md
# Eight-Channel Timer Register Front End

This block is the 32-bit memory-mapped register side of a bank of eight down-counting timers. A simple strobe bus (select, write, byte offset, data) reaches per-channel count, reload and two match registers, a shared control word and a second, free-use control word. The block holds the reload and match values and the per-channel configuration bits, and drives them to the counting logic. It returns read data one cycle after each access and raises an error pulse for accesses it does not accept. The counters are outside the block: their live values arrive on a flat count input, and writes to a count register leave as a one-cycle load strobe with a shared load value.

The control word holds one 4-bit field per channel. A control write does not update all bits at once. Channels being switched off stop first, the clock, interrupt and pulse options change next, and channels being switched on start last. The counting logic therefore never runs on a half-applied configuration. This takes three cycles, and a second control write in that time is refused.

The channel windows are split around the control registers. Channels 0 to 2 sit below them and channels 3 to 7 above them. Only channels 4 to 7 have the pulse output option.

Top module: `octal_timer_csr`

## Requirements
- R1: Within a channel window, word offset 0x0 is the count, 0x4 the reload, 0x8 the first match and 0xC the second match. Read data and the error flag appear on the cycle after the access is sampled.
- R2: Channel c < 3 has its window at c*16. Channel c >= 3 has its window at (c+1)*16, which covers 0x40 to 0x8F. The control word is at 0x30 and the second control word at 0x34.
- R3: In the control word, channel c owns bits 4c to 4c+3: 4c is run enable, 4c+1 external clock select, 4c+2 overflow interrupt enable and 4c+3 pulse mode. A read of the control word returns the applied bits.
- R4: Pulse mode can only be set on channels 4 to 7. A write that sets bit 4c+3 for c < 4 leaves that bit 0, applies the other bits and flags an error.
- R5: A control write sampled at edge E clears run enable of channels being disabled at E+1. It updates clock, interrupt and pulse bits at E+2. It sets run enable of channels being enabled at E+3.
- R6: An access with offset bits [1:0] nonzero, or to an offset outside R2's map, reads zero, flags an error and changes no state.
- R7: After reset every channel is stopped, uses the bus clock, and has overflow interrupt and pulse mode off. All stored registers read zero.
- R8: A count read returns the channel's live count input while the channel runs, and zero while it is stopped.
- R9: Reload and match reads return the last value written. The stored values are driven on the per-channel outputs.
- R10: The second control word is stored and read back, with no other effect.
- R11: A control write that arrives while a previous one is still being applied (the three cycles after its sampling edge) is dropped and flags an error.
- R12: A count write to a running channel pulses that channel's load strobe for one cycle, on the next cycle, with the written value. A count write to a stopped channel causes no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, cycle after the access |
| bus_err | output | 1 | Access refused or partly refused, cycle after the access |
| cnt_in | input | 256 | Live count per channel, 32 bits each, channel 0 in the low bits |
| ch_en | output | 8 | Run enable per channel |
| ch_extclk | output | 8 | External clock select per channel |
| ch_ovf_irq | output | 8 | Overflow interrupt enable per channel |
| ch_pulse | output | 8 | Pulse mode per channel |
| ch_reload | output | 256 | Reload value per channel |
| ch_match_a | output | 256 | First match value per channel |
| ch_match_b | output | 256 | Second match value per channel |
| ld_count | output | 8 | One-cycle count load strobe per channel |
| ld_value | output | 32 | Value for the count load |

## Verification
Control writes are tried from stopped to running with several options set at once, and then back to all clear. This separates the three update steps in time and shows a disable landing before the option change and an enable landing after it. Pulse requests are sent to a low channel and to a high channel, which separates the ignored case from the accepted one. Reads cover one channel on each side of the control gap, the two control words, a misaligned offset and unmapped offsets, and count reads with the channel stopped and running. Count writes to a stopped channel and to a running one show the load strobe is gated by run enable.

// File: rtl/tcsr_pkg.sv
package tcsr_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_DIS  = 2'd1,
    SQ_CFG  = 2'd2,
    SQ_ENA  = 2'd3
  } seq_t;

  typedef enum logic [2:0] {
    RK_NONE   = 3'd0,
    RK_COUNT  = 3'd1,
    RK_RELOAD = 3'd2,
    RK_MATCHA = 3'd3,
    RK_MATCHB = 3'd4,
    RK_CTRL   = 3'd5,
    RK_CTRL2  = 3'd6
  } rkind_t;

  // bit order equals the field order inside the control word
  typedef struct packed {
    logic pulse;
    logic ovf;
    logic ext;
    logic en;
  } cfg_t;

  function automatic rkind_t win_kind(input logic [1:0] word);
    case (word)
      2'd0:    return RK_COUNT;
      2'd1:    return RK_RELOAD;
      2'd2:    return RK_MATCHA;
      default: return RK_MATCHB;
    endcase
  endfunction
endpackage

// File: rtl/tcsr_decode.sv
module tcsr_decode
  import tcsr_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned LOW_CH = 3,
  parameter int unsigned AW     = 8,
  localparam int unsigned CW    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [AW-1:0] addr,
  output rkind_t        kind,
  output logic [CW-1:0] ch,
  output logic          misaligned
);
  localparam int LOW_END = int'(LOW_CH) * 16;
  localparam int HI_BASE = LOW_END + 16;
  localparam int HI_END  = HI_BASE + int'(N_CH - LOW_CH) * 16;

  assign misaligned = |addr[1:0];

  always_comb begin
    int a;
    a    = int'(addr);
    kind = RK_NONE;
    ch   = '0;
    if (!misaligned) begin
      if (a < LOW_END) begin
        kind = win_kind(addr[3:2]);
        ch   = CW'(a / 16);
      end else if (a == LOW_END) begin
        kind = RK_CTRL;
      end else if (a == LOW_END + 4) begin
        kind = RK_CTRL2;
      end else if (a >= HI_BASE && a < HI_END) begin
        kind = win_kind(addr[3:2]);
        ch   = CW'(a / 16 - 1);
      end
    end
  end
endmodule

// File: rtl/tcsr_seq.sv
module tcsr_seq
  import tcsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output seq_t st,
  output logic busy
);
  seq_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else begin
      case (st_q)
        SQ_IDLE: if (start) st_q <= SQ_DIS;
        SQ_DIS:  st_q <= SQ_CFG;
        SQ_CFG:  st_q <= SQ_ENA;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign st   = st_q;
  assign busy = (st_q != SQ_IDLE);

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_DIS) |-> $past(st_q == SQ_IDLE)); // R11
endmodule

// File: rtl/tcsr_chan.sv
module tcsr_chan
  import tcsr_pkg::*;
#(
  parameter bit CAN_PULSE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_t              st,
  input  cfg_t              pend,
  input  logic              wr_reload,
  input  logic              wr_match_a,
  input  logic              wr_match_b,
  input  logic [WORD_W-1:0] wdata,
  output cfg_t              cfg,
  output logic [WORD_W-1:0] reload,
  output logic [WORD_W-1:0] match_a,
  output logic [WORD_W-1:0] match_b
);
  cfg_t              cfg_q;
  logic [WORD_W-1:0] reload_q, match_a_q, match_b_q;
  logic              opt_pulse;

  assign opt_pulse = CAN_PULSE ? pend.pulse : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      case (st)
        SQ_DIS: if (!pend.en) cfg_q.en <= 1'b0;
        SQ_CFG: begin
          cfg_q.ext   <= pend.ext;
          cfg_q.ovf   <= pend.ovf;
          cfg_q.pulse <= opt_pulse;
        end
        SQ_ENA: if (pend.en) cfg_q.en <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q  <= '0;
      match_a_q <= '0;
      match_b_q <= '0;
    end else begin
      if (wr_reload)  reload_q  <= wdata;
      if (wr_match_a) match_a_q <= wdata;
      if (wr_match_b) match_b_q <= wdata;
    end
  end

  assign cfg     = cfg_q;
  assign reload  = reload_q;
  assign match_a = match_a_q;
  assign match_b = match_b_q;

  AST_EN_DROP_IN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_q.en) |-> $past(st == SQ_DIS)); // R5
  AST_EN_RISE_IN_ENA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q.en) |-> $past(st == SQ_ENA)); // R5
  AST_OPTS_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_q.ext, cfg_q.ovf, cfg_q.pulse}) |-> $past(st == SQ_CFG)); // R5
endmodule

// File: rtl/octal_timer_csr.sv
module octal_timer_csr
  import tcsr_pkg::*;
#(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned LOW_CH      = 3,
  parameter int unsigned PULSE_FIRST = 4,
  parameter int unsigned AW          = 8,
  localparam int unsigned CW         = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned FW         = N_CH * 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 bus_err,
  input  logic [N_CH*WORD_W-1:0] cnt_in,
  output logic [N_CH-1:0]      ch_en,
  output logic [N_CH-1:0]      ch_extclk,
  output logic [N_CH-1:0]      ch_ovf_irq,
  output logic [N_CH-1:0]      ch_pulse,
  output logic [N_CH*WORD_W-1:0] ch_reload,
  output logic [N_CH*WORD_W-1:0] ch_match_a,
  output logic [N_CH*WORD_W-1:0] ch_match_b,
  output logic [N_CH-1:0]      ld_count,
  output logic [WORD_W-1:0]    ld_value
);
  function automatic logic [FW-1:0] pulse_block_mask();
    logic [FW-1:0] m;
    m = '0;
    for (int i = 0; i < int'(N_CH); i++)
      if (i < int'(PULSE_FIRST)) m[4*i+3] = 1'b1;
    return m;
  endfunction

  localparam logic [FW-1:0] PULSE_BLOCK = pulse_block_mask();

  // decode
  rkind_t        dec_kind;
  logic [CW-1:0] dec_ch;
  logic          dec_misaligned;

  tcsr_decode #(.N_CH(N_CH), .LOW_CH(LOW_CH), .AW(AW)) u_dec (
    .addr       (bus_addr),
    .kind       (dec_kind),
    .ch         (dec_ch),
    .misaligned (dec_misaligned)
  );

  logic acc_wr, acc_rd, unmapped;
  assign acc_wr   = bus_sel && bus_wr;
  assign acc_rd   = bus_sel && !bus_wr;
  assign unmapped = (dec_kind == RK_NONE);

  // control sequencing
  seq_t st;
  logic busy, ctrl_wr, ctrl_start, pulse_reject;
  logic [FW-1:0] pend_q;

  assign ctrl_wr      = acc_wr && (dec_kind == RK_CTRL);
  assign ctrl_start   = ctrl_wr && !busy;
  assign pulse_reject = |(bus_wdata[FW-1:0] & PULSE_BLOCK);

  tcsr_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ctrl_start),
    .st    (st),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (ctrl_start) pend_q <= bus_wdata[FW-1:0] & ~PULSE_BLOCK;
  end

  // second control word
  logic [WORD_W-1:0] ctrl2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl2_q <= '0;
    else if (acc_wr && dec_kind == RK_CTRL2) ctrl2_q <= bus_wdata;
  end

  // channels
  cfg_t              cfg_q    [N_CH];
  logic [WORD_W-1:0] reload_w [N_CH];
  logic [WORD_W-1:0] match_aw [N_CH];
  logic [WORD_W-1:0] match_bw [N_CH];
  logic [WORD_W-1:0] cnt_w    [N_CH];
  logic [FW-1:0]     ctrl_rd;

  for (genvar i = 0; i < int'(N_CH); i++) begin : g_ch
    logic sel_i;
    assign sel_i = acc_wr && (dec_ch == CW'(i));

    tcsr_chan #(.CAN_PULSE((i >= int'(PULSE_FIRST)) ? 1'b1 : 1'b0)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .st         (st),
      .pend       (cfg_t'(pend_q[4*i +: 4])),
      .wr_reload  (sel_i && dec_kind == RK_RELOAD),
      .wr_match_a (sel_i && dec_kind == RK_MATCHA),
      .wr_match_b (sel_i && dec_kind == RK_MATCHB),
      .wdata      (bus_wdata),
      .cfg        (cfg_q[i]),
      .reload     (reload_w[i]),
      .match_a    (match_aw[i]),
      .match_b    (match_bw[i])
    );

    assign ch_en[i]      = cfg_q[i].en;
    assign ch_extclk[i]  = cfg_q[i].ext;
    assign ch_ovf_irq[i] = cfg_q[i].ovf;
    assign ch_pulse[i]   = cfg_q[i].pulse;
    assign ctrl_rd[4*i +: 4] = cfg_q[i];
    assign ch_reload [WORD_W*i +: WORD_W] = reload_w[i];
    assign ch_match_a[WORD_W*i +: WORD_W] = match_aw[i];
    assign ch_match_b[WORD_W*i +: WORD_W] = match_bw[i];
    assign cnt_w[i] = cnt_in[WORD_W*i +: WORD_W];
  end

  // read mux
  logic [WORD_W-1:0] rd_val;
  always_comb begin
    case (dec_kind)
      RK_COUNT:  rd_val = ch_en[dec_ch] ? cnt_w[dec_ch] : '0;
      RK_RELOAD: rd_val = reload_w[dec_ch];
      RK_MATCHA: rd_val = match_aw[dec_ch];
      RK_MATCHB: rd_val = match_bw[dec_ch];
      RK_CTRL:   rd_val = WORD_W'(ctrl_rd);
      RK_CTRL2:  rd_val = ctrl2_q;
      default:   rd_val = '0;
    endcase
  end

  // response, error and load strobes
  logic access_bad;
  assign access_bad = bus_sel && (unmapped || (ctrl_wr && (busy || pulse_reject)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      ld_count  <= '0;
      ld_value  <= '0;
    end else begin
      bus_rdata <= acc_rd ? rd_val : '0;
      bus_err   <= access_bad;
      ld_count  <= '0;
      if (acc_wr && dec_kind == RK_COUNT && ch_en[dec_ch]) begin
        ld_count[dec_ch] <= 1'b1;
        ld_value         <= bus_wdata;
      end
    end
  end

  AST_NO_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_pulse & N_CH'(~0 << PULSE_FIRST)) == ch_pulse); // R4
  AST_BAD_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && unmapped) |=> (bus_err && bus_rdata == '0)); // R6
  AST_BUSY_CTRL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy) |=> bus_err); // R11
  AST_STOPPED_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && dec_kind == RK_COUNT && !ch_en[dec_ch]) |=> (bus_rdata == '0)); // R8
  AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|ld_count) |-> $past(acc_wr && dec_kind == RK_COUNT)); // R12
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_count)); // R12
endmodule

// File: tb/octal_timer_csr_tb.sv
`timescale 1ns/1ps
module octal_timer_csr_tb;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic [NC*32-1:0] cnt_in = '0;
  logic [NC-1:0] ch_en, ch_extclk, ch_ovf_irq, ch_pulse, ld_count;
  logic [NC*32-1:0] ch_reload, ch_match_a, ch_match_b;
  logic [31:0]   ld_value;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  octal_timer_csr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .cnt_in(cnt_in), .ch_en(ch_en), .ch_extclk(ch_extclk),
    .ch_ovf_irq(ch_ovf_irq), .ch_pulse(ch_pulse), .ch_reload(ch_reload),
    .ch_match_a(ch_match_a), .ch_match_b(ch_match_b), .ld_count(ld_count),
    .ld_value(ld_value)
  );

  function automatic logic [7:0] reg_addr(input int ch, input int word);
    int base;
    base = (ch < 3) ? ch * 16 : (ch + 1) * 16;
    return 8'(base + word * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // each access: driven at a falling edge, sampled at the next rise,
  // response read at the falling edge after that
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    err = bus_err;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata; err = bus_err;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R7 en", 32'(ch_en), 0);
    chk("R7 extclk", 32'(ch_extclk), 0);
    chk("R7 ovf", 32'(ch_ovf_irq), 0);
    chk("R7 pulse", 32'(ch_pulse), 0);
    bus_read(8'h30, d, e); chk("R7 ctrl read", d, 0);
    bus_read(reg_addr(6, 1), d, e); chk("R7 reload read", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d; logic e;
    bus_write(reg_addr(0, 1), 32'h1111_0001, e);
    bus_write(reg_addr(0, 2), 32'h2222_0002, e);
    bus_write(reg_addr(0, 3), 32'h3333_0003, e);
    bus_write(reg_addr(5, 1), 32'hAAAA_0005, e);
    bus_write(reg_addr(2, 1), 32'h0000_0202, e);
    bus_write(reg_addr(3, 1), 32'h0000_0303, e);
    bus_read(reg_addr(0, 1), d, e); chk("R1 R9 reload ch0", d, 32'h1111_0001);
    bus_read(reg_addr(0, 2), d, e); chk("R1 R9 match_a ch0", d, 32'h2222_0002);
    bus_read(reg_addr(0, 3), d, e); chk("R1 R9 match_b ch0", d, 32'h3333_0003);
    bus_read(8'h64, d, e); chk("R2 ch5 at 0x64", d, 32'hAAAA_0005);
    bus_read(8'h24, d, e); chk("R2 ch2 at 0x24", d, 32'h0000_0202);
    bus_read(8'h44, d, e); chk("R2 ch3 at 0x44", d, 32'h0000_0303);
    chk("R9 reload out ch5", ch_reload[5*32 +: 32], 32'hAAAA_0005);
    chk("R9 match_b out ch0", ch_match_b[31:0], 32'h3333_0003);
  endtask

  task automatic t_ctrl2();
    logic [31:0] d; logic e;
    bus_write(8'h34, 32'hDEAD_BEEF, e);
    bus_read(8'h34, d, e); chk("R10 ctrl2 readback", d, 32'hDEAD_BEEF);
    chk("R10 no side effect", 32'(ch_en), 0);
  endtask

  task automatic t_sequence();
    logic e;
    // channel 1: run + external clock + overflow irq (field 0b0111 at bits 7:4)
    bus_write(8'h30, 32'h0000_0070, e);
    chk("R5 no err", 32'(e), 0);
    @(negedge clk);
    chk("R5 E+1 en still low", 32'(ch_en[1]), 0);
    chk("R5 E+1 ext not yet", 32'(ch_extclk[1]), 0);
    @(negedge clk);
    chk("R5 E+2 ext set", 32'(ch_extclk[1]), 1);
    chk("R5 E+2 ovf set", 32'(ch_ovf_irq[1]), 1);
    chk("R5 E+2 en still low", 32'(ch_en[1]), 0);
    @(negedge clk);
    chk("R5 E+3 en high", 32'(ch_en[1]), 1);
    // clear the field again
    bus_write(8'h30, 32'h0000_0000, e);
    @(negedge clk);
    chk("R5 E+1 en dropped", 32'(ch_en[1]), 0);
    chk("R5 E+1 ext kept", 32'(ch_extclk[1]), 1);
    @(negedge clk);
    chk("R5 E+2 ext cleared", 32'(ch_extclk[1]), 0);
    @(negedge clk);
  endtask

  task automatic t_pulse();
    logic [31:0] d; logic e;
    // ch2 pulse (bit 11) with run (bit 8); ch6 pulse (bit 27)
    bus_write(8'h30, 32'h0800_0900, e);
    chk("R4 low pulse flags err", 32'(e), 1);
    settle();
    chk("R4 ch2 pulse ignored", 32'(ch_pulse[2]), 0);
    chk("R4 ch2 run applied", 32'(ch_en[2]), 1);
    chk("R4 ch6 pulse accepted", 32'(ch_pulse[6]), 1);
    bus_read(8'h30, d, e); chk("R3 ctrl read", d, 32'h0800_0100);
    bus_write(8'h30, 32'h0800_0000, e);
    chk("R4 high pulse no err", 32'(e), 0);
    settle();
  endtask

  task automatic t_busy();
    logic [31:0] d; logic e;
    bus_write(8'h30, 32'h0000_0004, e);
    bus_write(8'h30, 32'h0000_0001, e);
    chk("R11 busy write err", 32'(e), 1);
    settle();
    bus_read(8'h30, d, e); chk("R11 second write dropped", d, 32'h0000_0004);
  endtask

  task automatic t_bad();
    logic [31:0] d; logic e;
    bus_read(8'h38, d, e);
    chk("R6 unmapped 0x38 err", 32'(e), 1); chk("R6 unmapped 0x38 data", d, 0);
    bus_read(8'h90, d, e); chk("R6 unmapped 0x90 err", 32'(e), 1);
    bus_read(8'h06, d, e); chk("R6 misaligned err", 32'(e), 1); chk("R6 misaligned data", d, 0);
    bus_write(8'h05, 32'hFFFF_FFFF, e); chk("R6 misaligned write err", 32'(e), 1);
    bus_read(reg_addr(0, 1), d, e); chk("R6 write had no effect", d, 32'h1111_0001);
  endtask

  task automatic t_count();
    logic [31:0] d; logic e;
    for (int i = 0; i < NC; i++) cnt_in[32*i +: 32] = 32'hC0DE_0000 + 32'(i);
    bus_read(reg_addr(0, 0), d, e); chk("R8 stopped reads zero", d, 0);
    bus_write(8'h30, 32'h0000_1001, e);  // ch0 and ch3 run
    settle();
    bus_read(reg_addr(0, 0), d, e); chk("R8 live count ch0", d, 32'hC0DE_0000);
    bus_read(reg_addr(3, 0), d, e); chk("R8 live count ch3", d, 32'hC0DE_0003);
    bus_write(reg_addr(3, 0), 32'h0000_0055, e);
    chk("R12 strobe ch3", 32'(ld_count), 32'h08);
    chk("R12 load value", ld_value, 32'h0000_0055);
    @(negedge clk);
    chk("R12 strobe one cycle", 32'(ld_count), 0);
    bus_write(reg_addr(4, 0), 32'h0000_0077, e);
    chk("R12 stopped no strobe", 32'(ld_count), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ctrl2();
    t_sequence();
    t_pulse();
    t_busy();
    t_bad();
    t_count();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule